// File: doc/BRIEF.md
# Hotplug General-Purpose Event Registers

This block holds the event and bitmap registers that firmware polls when a processor or a PCI slot is added or removed at run time. It keeps a 16-bit event status register, a 16-bit event enable register, two 8-bit processor bitmaps (arrived and departed) and two 32-bit slot bitmaps (arrived and departed). Two byte-wide windows give access to the event registers and the processor bitmaps. A 32-bit window gives access to the slot bitmaps.

The platform reports a hotplug event with a one-cycle request that carries an add or remove flag and the processor or slot index. The block then clears the matching pair of bitmaps, sets the index bit in one of them, forces the class bit in both the status and enable registers, and pulses the system control interrupt (`sciOut`) for one cycle. If a processor request and a slot request arrive in the same cycle, the processor request is served first and the slot request on the next edge.

Firmware reports that a removal has finished by writing a one-hot (or any) mask to a 32-bit eject port. The block turns the lowest set bit of the mask into a slot number and gives a one-cycle completion strobe that the device-removal logic consumes. Reads of the eject port return zero.

Top module: `hp_gpe_top`

## Requirements
- R1: After reset, every register reads zero, and `sciOut` and `ejectStrobe` are low.
- R2: With `byteSel`=0, byte offsets 0 and 1 read and write the low and high bytes of the event status register, and offsets 2 and 3 read and write the low and high bytes of the event enable register.
- R3: With `byteSel`=1, offset 0 reads and writes the processor arrived bitmap and offset 1 reads and writes the processor departed bitmap. Offsets 2 and 3 read zero, and writes to them change nothing.
- R4: `slotAddr`=0 reads and writes the 32-bit slot arrived bitmap and `slotAddr`=4 reads and writes the slot departed bitmap. Any other offset reads zero, and writes to it change nothing.
- R5: A served processor request clears both processor bitmaps. It then sets bit `cpuId` of the arrived map (when `cpuAdd`=1) or of the departed map (when `cpuAdd`=0), and sets bit 0 of both event status and event enable. The other event bits keep their values. The result is visible in the cycle after the request edge.
- R6: A served slot request clears both slot bitmaps. It then sets bit `slotId` of the arrived map (when `slotAdd`=1) or of the departed map (when `slotAdd`=0), and sets bit 1 of both event status and event enable. The other event bits keep their values.
- R7: `sciOut` is high for exactly one cycle, the cycle after the edge that serves a request. It is low otherwise.
- R8: When a processor request and a slot request arrive in the same cycle, the processor request is applied at that edge and the slot request at the following edge. `sciOut` stays high for both of the following cycles.
- R9: A write of a nonzero value to the eject port raises `ejectStrobe` for one cycle, in the cycle after the write edge. In that cycle `ejectSlot` holds the index of the lowest set bit of the written value.
- R10: An eject write of zero produces no strobe, and `ejectRdData` always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteSel | input | 1 | 0 = event window, 1 = processor window |
| byteAddr | input | 2 | Byte offset within the selected window |
| byteWrEn | input | 1 | Byte write strobe |
| byteWrData | input | 8 | Byte write data |
| byteRdData | output | 8 | Byte read data (combinational) |
| slotWrEn | input | 1 | Slot window write strobe |
| slotAddr | input | 3 | Slot window offset (0 or 4) |
| slotWrData | input | 32 | Slot window write data |
| slotRdData | output | 32 | Slot window read data (combinational) |
| ejectWrEn | input | 1 | Eject port write strobe |
| ejectWrData | input | 32 | Eject port write mask |
| ejectRdData | output | 32 | Eject port read data, always zero |
| cpuReq | input | 1 | Processor hotplug request, one cycle |
| cpuAdd | input | 1 | 1 = processor added, 0 = removed |
| cpuId | input | 3 | Processor index |
| slotReq | input | 1 | Slot hotplug request, one cycle |
| slotAdd | input | 1 | 1 = slot added, 0 = removed |
| slotId | input | 5 | Slot index |
| sciOut | output | 1 | System control interrupt pulse |
| ejectStrobe | output | 1 | Removal-complete strobe |
| ejectSlot | output | 5 | Slot index for the removal-complete strobe |

## Verification
A wrong bitmap or event bit shows at the read windows as soon as the request edge has passed, so the bench reads the registers in the next cycle. Stale bits from an earlier event would show as a second set bit in a bitmap. A lost or late pending slot request shows as slot bitmaps that have not changed one cycle after the processor result appears, together with an interrupt that is only one cycle long. An error in the eject path shows within one cycle as a wrong `ejectSlot` or as a strobe that is missing or unwanted.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int CPU_COUNT  = 8;
  localparam int SLOT_COUNT = 32;
  localparam int EVT_W      = 16;
  localparam int CPU_IDX_W  = $clog2(CPU_COUNT);
  localparam int SLOT_IDX_W = $clog2(SLOT_COUNT);

  localparam int CPU_EVT_BIT  = 0;
  localparam int SLOT_EVT_BIT = 1;

  typedef struct packed {
    logic                  cpuEvt;
    logic                  cpuAdd;
    logic [CPU_IDX_W-1:0]  cpuId;
    logic                  slotEvt;
    logic                  slotAdd;
    logic [SLOT_IDX_W-1:0] slotId;
  } hpStrobe_t;

  function automatic logic [SLOT_IDX_W-1:0] lowestSet(input logic [SLOT_COUNT-1:0] v);
    logic [SLOT_IDX_W-1:0] idx;
    idx = '0;
    for (int i = SLOT_COUNT - 1; i >= 0; i--) begin
      if (v[i]) idx = SLOT_IDX_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuReq,
  input  logic                  cpuAdd,
  input  logic [CPU_IDX_W-1:0]  cpuId,
  input  logic                  slotReq,
  input  logic                  slotAdd,
  input  logic [SLOT_IDX_W-1:0] slotId,
  input  logic                  ejectWrEn,
  input  logic [SLOT_COUNT-1:0] ejectWrData,
  output hpStrobe_t             strb,
  output logic                  sciOut,
  output logic                  ejectStrobe,
  output logic [SLOT_IDX_W-1:0] ejectSlot
);
  logic                  pendValid;
  logic                  pendAdd;
  logic [SLOT_IDX_W-1:0] pendId;

  // processor requests win; a displaced slot request waits one edge
  always_comb begin
    strb         = '0;
    strb.cpuEvt  = cpuReq;
    strb.cpuAdd  = cpuAdd;
    strb.cpuId   = cpuId;
    strb.slotEvt = !cpuReq && (pendValid || slotReq);
    strb.slotAdd = pendValid ? pendAdd : slotAdd;
    strb.slotId  = pendValid ? pendId : slotId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendAdd     <= 1'b0;
      pendId      <= '0;
      sciOut      <= 1'b0;
      ejectStrobe <= 1'b0;
      ejectSlot   <= '0;
    end else begin
      sciOut <= strb.cpuEvt || strb.slotEvt;
      if (slotReq && (cpuReq || pendValid)) begin
        pendValid <= 1'b1;
        pendAdd   <= slotAdd;
        pendId    <= slotId;
      end else if (strb.slotEvt) begin
        pendValid <= 1'b0;
      end
      ejectStrobe <= ejectWrEn && (|ejectWrData);
      if (ejectWrEn) ejectSlot <= lowestSet(ejectWrData);
    end
  end

  AST_SCI_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq || slotReq) |=> sciOut); // R7
  AST_SLOT_AFTER_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && slotReq) |=> (strb.slotEvt || cpuReq)); // R8
  AST_EJECT_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ejectWrEn && ejectWrData == '0) |=> !ejectStrobe); // R10
  AST_EJECT_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    ejectStrobe |-> ((($past(ejectWrData) >> ejectSlot) & SLOT_COUNT'(1)) != '0)); // R9
endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  hpStrobe_t             strb,
  input  logic                  byteSel,
  input  logic [1:0]            byteAddr,
  input  logic                  byteWrEn,
  input  logic [7:0]            byteWrData,
  output logic [7:0]            byteRdData,
  input  logic                  slotWrEn,
  input  logic [2:0]            slotAddr,
  input  logic [SLOT_COUNT-1:0] slotWrData,
  output logic [SLOT_COUNT-1:0] slotRdData
);
  logic [EVT_W-1:0]      evtSts, evtEn;
  logic [CPU_COUNT-1:0]  cpuUp, cpuDown;
  logic [SLOT_COUNT-1:0] slotUp, slotDown;
  logic [CPU_COUNT-1:0]  cpuOneHot;
  logic [SLOT_COUNT-1:0] slotOneHot;

  assign cpuOneHot  = CPU_COUNT'(1) << strb.cpuId;
  assign slotOneHot = SLOT_COUNT'(1) << strb.slotId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtSts   <= '0;
      evtEn    <= '0;
      cpuUp    <= '0;
      cpuDown  <= '0;
      slotUp   <= '0;
      slotDown <= '0;
    end else begin
      if (byteWrEn && !byteSel) begin
        case (byteAddr)
          2'd0: evtSts[7:0]  <= byteWrData;
          2'd1: evtSts[15:8] <= byteWrData;
          2'd2: evtEn[7:0]   <= byteWrData;
          default: evtEn[15:8] <= byteWrData;
        endcase
      end
      if (byteWrEn && byteSel) begin
        case (byteAddr)
          2'd0: cpuUp   <= byteWrData;
          2'd1: cpuDown <= byteWrData;
          default: ;
        endcase
      end
      if (slotWrEn) begin
        if (slotAddr == 3'd0) slotUp   <= slotWrData;
        if (slotAddr == 3'd4) slotDown <= slotWrData;
      end
      // hotplug events override a bus write in the same cycle
      if (strb.cpuEvt) begin
        evtSts[CPU_EVT_BIT] <= 1'b1;
        evtEn[CPU_EVT_BIT]  <= 1'b1;
        cpuUp   <= strb.cpuAdd ? cpuOneHot : '0;
        cpuDown <= strb.cpuAdd ? '0 : cpuOneHot;
      end
      if (strb.slotEvt) begin
        evtSts[SLOT_EVT_BIT] <= 1'b1;
        evtEn[SLOT_EVT_BIT]  <= 1'b1;
        slotUp   <= strb.slotAdd ? slotOneHot : '0;
        slotDown <= strb.slotAdd ? '0 : slotOneHot;
      end
    end
  end

  always_comb begin
    byteRdData = '0;
    if (!byteSel) begin
      case (byteAddr)
        2'd0: byteRdData = evtSts[7:0];
        2'd1: byteRdData = evtSts[15:8];
        2'd2: byteRdData = evtEn[7:0];
        default: byteRdData = evtEn[15:8];
      endcase
    end else begin
      case (byteAddr)
        2'd0: byteRdData = cpuUp;
        2'd1: byteRdData = cpuDown;
        default: byteRdData = '0;
      endcase
    end
  end

  always_comb begin
    case (slotAddr)
      3'd0: slotRdData = slotUp;
      3'd4: slotRdData = slotDown;
      default: slotRdData = '0;
    endcase
  end

  AST_CPU_EVT_MARK: assert property (@(posedge clk) disable iff (!rstN)
    strb.cpuEvt |=> (evtSts[CPU_EVT_BIT] && evtEn[CPU_EVT_BIT]
                     && $countones({cpuUp, cpuDown}) == 1)); // R5
  AST_CPU_ADD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cpuEvt && strb.cpuAdd) |=> cpuUp[$past(strb.cpuId)]); // R5
  AST_SLOT_EVT_MARK: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotEvt |=> (evtSts[SLOT_EVT_BIT] && evtEn[SLOT_EVT_BIT]
                      && $countones({slotUp, slotDown}) == 1)); // R6
endmodule

// File: rtl/hp_gpe_top.sv
module hp_gpe_top
  import hp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteSel,
  input  logic [1:0]            byteAddr,
  input  logic                  byteWrEn,
  input  logic [7:0]            byteWrData,
  output logic [7:0]            byteRdData,
  input  logic                  slotWrEn,
  input  logic [2:0]            slotAddr,
  input  logic [SLOT_COUNT-1:0] slotWrData,
  output logic [SLOT_COUNT-1:0] slotRdData,
  input  logic                  ejectWrEn,
  input  logic [SLOT_COUNT-1:0] ejectWrData,
  output logic [SLOT_COUNT-1:0] ejectRdData,
  input  logic                  cpuReq,
  input  logic                  cpuAdd,
  input  logic [CPU_IDX_W-1:0]  cpuId,
  input  logic                  slotReq,
  input  logic                  slotAdd,
  input  logic [SLOT_IDX_W-1:0] slotId,
  output logic                  sciOut,
  output logic                  ejectStrobe,
  output logic [SLOT_IDX_W-1:0] ejectSlot
);
  hpStrobe_t strb;

  assign ejectRdData = '0;

  hp_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuAdd(cpuAdd), .cpuId(cpuId),
    .slotReq(slotReq), .slotAdd(slotAdd), .slotId(slotId),
    .ejectWrEn(ejectWrEn), .ejectWrData(ejectWrData),
    .strb(strb), .sciOut(sciOut),
    .ejectStrobe(ejectStrobe), .ejectSlot(ejectSlot)
  );

  hp_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .byteSel(byteSel), .byteAddr(byteAddr), .byteWrEn(byteWrEn),
    .byteWrData(byteWrData), .byteRdData(byteRdData),
    .slotWrEn(slotWrEn), .slotAddr(slotAddr),
    .slotWrData(slotWrData), .slotRdData(slotRdData)
  );
endmodule

// File: tb/tb_hp_gpe_top.sv
`timescale 1ns/1ps
module tb_hp_gpe_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteSel = 1'b0;
  logic [1:0]  byteAddr = '0;
  logic        byteWrEn = 1'b0;
  logic [7:0]  byteWrData = '0;
  logic [7:0]  byteRdData;
  logic        slotWrEn = 1'b0;
  logic [2:0]  slotAddr = '0;
  logic [31:0] slotWrData = '0;
  logic [31:0] slotRdData;
  logic        ejectWrEn = 1'b0;
  logic [31:0] ejectWrData = '0;
  logic [31:0] ejectRdData;
  logic        cpuReq = 1'b0, cpuAdd = 1'b0;
  logic [2:0]  cpuId = '0;
  logic        slotReq = 1'b0, slotAdd = 1'b0;
  logic [4:0]  slotId = '0;
  logic        sciOut, ejectStrobe;
  logic [4:0]  ejectSlot;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hp_gpe_top dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic byteWrite(input logic sel, input logic [1:0] a, input logic [7:0] d);
    byteSel = sel; byteAddr = a; byteWrData = d; byteWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    byteWrEn = 1'b0;
  endtask

  task automatic byteRead(input logic sel, input logic [1:0] a, output logic [7:0] d);
    byteSel = sel; byteAddr = a;
    #1 d = byteRdData;
  endtask

  task automatic slotWrite(input logic [2:0] a, input logic [31:0] d);
    slotAddr = a; slotWrData = d; slotWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    slotWrEn = 1'b0;
  endtask

  task automatic slotRead(input logic [2:0] a, output logic [31:0] d);
    slotAddr = a;
    #1 d = slotRdData;
  endtask

  task automatic testReset();
    logic [7:0] b; logic [31:0] w;
    check("R1 sci at reset", 32'(sciOut), 0);
    check("R1 eject strobe at reset", 32'(ejectStrobe), 0);
    for (int i = 0; i < 4; i++) begin
      byteRead(1'b0, 2'(i), b); check("R1 event byte at reset", 32'(b), 0);
    end
    byteRead(1'b1, 2'd0, b); check("R1 cpu up at reset", 32'(b), 0);
    byteRead(1'b1, 2'd1, b); check("R1 cpu down at reset", 32'(b), 0);
    slotRead(3'd0, w); check("R1 slot up at reset", w, 0);
    slotRead(3'd4, w); check("R1 slot down at reset", w, 0);
  endtask

  task automatic testEventBytes();
    logic [7:0] b;
    byteWrite(1'b0, 2'd0, 8'hA5);
    byteWrite(1'b0, 2'd1, 8'h3C);
    byteWrite(1'b0, 2'd2, 8'h5A);
    byteWrite(1'b0, 2'd3, 8'hC3);
    byteRead(1'b0, 2'd0, b); check("R2 status low", 32'(b), 32'hA5);
    byteRead(1'b0, 2'd1, b); check("R2 status high", 32'(b), 32'h3C);
    byteRead(1'b0, 2'd2, b); check("R2 enable low", 32'(b), 32'h5A);
    byteRead(1'b0, 2'd3, b); check("R2 enable high", 32'(b), 32'hC3);
    byteWrite(1'b0, 2'd0, 8'h00);
    byteWrite(1'b0, 2'd1, 8'h80);
    byteWrite(1'b0, 2'd2, 8'h00);
    byteWrite(1'b0, 2'd3, 8'h00);
  endtask

  task automatic testCpuWindow();
    logic [7:0] b;
    byteWrite(1'b1, 2'd0, 8'h12);
    byteWrite(1'b1, 2'd1, 8'h34);
    byteWrite(1'b1, 2'd2, 8'hFF);
    byteRead(1'b1, 2'd0, b); check("R3 cpu up map", 32'(b), 32'h12);
    byteRead(1'b1, 2'd1, b); check("R3 cpu down map", 32'(b), 32'h34);
    byteRead(1'b1, 2'd2, b); check("R3 unused offset reads zero", 32'(b), 0);
    byteRead(1'b1, 2'd3, b); check("R3 unused offset reads zero", 32'(b), 0);
  endtask

  task automatic testSlotWindow();
    logic [31:0] w;
    slotWrite(3'd0, 32'hDEADBEEF);
    slotWrite(3'd4, 32'h01234567);
    slotWrite(3'd2, 32'hFFFFFFFF);
    slotRead(3'd0, w); check("R4 slot up map", w, 32'hDEADBEEF);
    slotRead(3'd4, w); check("R4 slot down map", w, 32'h01234567);
    slotRead(3'd2, w); check("R4 unused offset reads zero", w, 0);
  endtask

  task automatic cpuRequest(input logic add, input logic [2:0] id);
    cpuReq = 1'b1; cpuAdd = add; cpuId = id;
    @(posedge clk); @(negedge clk);
    cpuReq = 1'b0;
    check("R7 sci high after processor request", 32'(sciOut), 1);
  endtask

  task automatic slotRequest(input logic add, input logic [4:0] id);
    slotReq = 1'b1; slotAdd = add; slotId = id;
    @(posedge clk); @(negedge clk);
    slotReq = 1'b0;
    check("R7 sci high after slot request", 32'(sciOut), 1);
  endtask

  task automatic testCpuRequests();
    logic [7:0] b;
    cpuRequest(1'b1, 3'd5);
    byteRead(1'b1, 2'd0, b); check("R5 add sets up bit", 32'(b), 32'h20);
    byteRead(1'b1, 2'd1, b); check("R5 add clears down map", 32'(b), 0);
    byteRead(1'b0, 2'd0, b); check("R5 status bit0", 32'(b), 32'h01);
    byteRead(1'b0, 2'd1, b); check("R5 status high kept", 32'(b), 32'h80);
    byteRead(1'b0, 2'd2, b); check("R5 enable bit0", 32'(b), 32'h01);
    @(posedge clk); @(negedge clk);
    check("R7 sci lasts one cycle", 32'(sciOut), 0);
    cpuRequest(1'b0, 3'd2);
    byteRead(1'b1, 2'd0, b); check("R5 remove clears up map", 32'(b), 0);
    byteRead(1'b1, 2'd1, b); check("R5 remove sets down bit", 32'(b), 32'h04);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic testSlotRequests();
    logic [31:0] w; logic [7:0] b;
    slotRequest(1'b1, 5'd31);
    slotRead(3'd0, w); check("R6 add sets up bit", w, 32'h80000000);
    slotRead(3'd4, w); check("R6 add clears down map", w, 0);
    byteRead(1'b0, 2'd0, b); check("R6 status bit1 set", 32'(b), 32'h03);
    byteRead(1'b0, 2'd2, b); check("R6 enable bit1 set", 32'(b), 32'h03);
    @(posedge clk); @(negedge clk);
    check("R7 sci low after slot pulse", 32'(sciOut), 0);
    slotRequest(1'b0, 5'd0);
    slotRead(3'd0, w); check("R6 remove clears up map", w, 0);
    slotRead(3'd4, w); check("R6 remove sets down bit", w, 32'h00000001);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic testSimultaneous();
    logic [31:0] w; logic [7:0] b;
    cpuReq = 1'b1; cpuAdd = 1'b1; cpuId = 3'd1;
    slotReq = 1'b1; slotAdd = 1'b0; slotId = 5'd7;
    @(posedge clk); @(negedge clk);
    cpuReq = 1'b0; slotReq = 1'b0;
    check("R8 sci first cycle", 32'(sciOut), 1);
    byteRead(1'b1, 2'd0, b); check("R8 processor served first", 32'(b), 32'h02);
    slotRead(3'd4, w); check("R8 slot not yet served", w, 32'h00000001);
    @(posedge clk); @(negedge clk);
    check("R8 sci second cycle", 32'(sciOut), 1);
    slotRead(3'd4, w); check("R8 slot served next edge", w, 32'h00000080);
    slotRead(3'd0, w); check("R8 slot up cleared", w, 0);
    @(posedge clk); @(negedge clk);
    check("R8 sci low afterwards", 32'(sciOut), 0);
  endtask

  task automatic ejectWrite(input logic [31:0] d);
    ejectWrData = d; ejectWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    ejectWrEn = 1'b0;
  endtask

  task automatic testEject();
    ejectWrite(32'h00000050);
    check("R9 strobe on nonzero eject", 32'(ejectStrobe), 1);
    check("R9 lowest set bit index", 32'(ejectSlot), 4);
    @(posedge clk); @(negedge clk);
    check("R9 strobe lasts one cycle", 32'(ejectStrobe), 0);
    ejectWrite(32'h80000000);
    check("R9 strobe for top slot", 32'(ejectStrobe), 1);
    check("R9 top slot index", 32'(ejectSlot), 31);
    ejectWrite(32'h00000000);
    check("R10 zero eject gives no strobe", 32'(ejectStrobe), 0);
    check("R10 eject port reads zero", ejectRdData, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEventBytes();
    testCpuWindow();
    testSlotWindow();
    testCpuRequests();
    testSlotRequests();
    testSimultaneous();
    testEject();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule